// File: doc/BRIEF.md
# Five-Port Switch Allocator and Crossbar

This block is the shared switching stage of a five-port mesh router with ports north, south, east, west and local. Each input port presents a request vector naming the output it wants. Dimension-order routing means an input asks for at most one output, so arbitration only has to settle contention at the outputs. One least-recently-granted arbiter sits behind each output. Its one-hot grant vector drives that output's multiplexer in a 5x5 crossbar directly, with no encode step. The crossbar carries 16-bit flits.

A flow-control input per output reports whether the downstream neighbour can take a flit. While it is off, that output issues no grant and its arbiter keeps its priority order. Header flits are narrower than the datapath and are zero-padded as they enter the crossbar. Grants are also folded per input and returned in the same cycle, so each input port knows that its flit was taken.

Grants are combinational from the current requests and the arbiter state. Arbiter state changes only on a rising clock edge on which that arbiter grants.

Top module: `sa_switch_alloc`

## Requirements
- R1: Each output grants at most one input in any cycle. Grant bit `out_gnt[o*5+i]` means that input i is granted output o. Port index 0..4 stands for north, south, east, west, local.
- R2: An output grants only an input that requests it. Request bit `req[i*5+o]` means that input i requests output o.
- R3: While `flow_on[o]` is low, output o grants nobody, `out_valid[o]` is low, and the priority order of its arbiter is not changed.
- R4: When `flow_on[o]` is high and at least one input requests output o, output o grants an input in that same cycle.
- R5: Each output grants the requesting input that was granted by it least recently. After reset the order from highest to lowest priority is index 0, 1, 2, 3, 4. The input just granted drops to lowest priority and the others keep their relative order.
- R6: A granted output drives `out_valid[o]` high and carries the granted input's flit on `out_data[o*16 +: 16]`. Input i's flit is `in_data[i*16 +: 16]`.
- R7: An output with no grant drives `out_valid[o]` low and all-zero data.
- R8: When `in_hdr[i]` is high, bits 15..11 of input i's flit reach the output as zeros and bits 10..0 pass unchanged.
- R9: `in_grant[i]` is high in the same cycle exactly when some output grants input i.
- R10: While `rst_n` is low, all grants and valids are low. Leaving reset restores the priority order of R5 on every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 25 | Request matrix, bit i*5+o = input i wants output o |
| flow_on | input | 5 | Per output, high when downstream can accept a flit |
| in_data | input | 80 | Flit per input, slice i*16 +: 16 |
| in_hdr | input | 5 | Per input, high when the flit is a narrow header |
| out_data | output | 80 | Flit per output, slice o*16 +: 16 |
| out_valid | output | 5 | Per output, high when a flit is sent |
| out_gnt | output | 25 | Grant matrix, bit o*5+i = output o grants input i |
| in_grant | output | 5 | Per input, high when any output grants it |

## Verification
The main function is driven with all five inputs contending for one output. This separates a true least-recently-granted order from a fixed-priority or plain round-robin scheme, because the winner sequence diverges once a subset of inputs requests. A permutation pattern, where every input asks for a different output, tests that the crossbar and the per-input grant return route each flit correctly and pad headers by source. Patterns that turn flow control off for a contended output show whether the arbiter state is frozen. A mid-run reset shows whether the priority order is restored. Idle cycles check that the outputs are zero.

// File: rtl/sa_pkg.sv
// Package: shared constants and port naming for the switch allocator.
// Assumes the router has five ports indexed north, south, east, west, local.
package sa_pkg;
    parameter int SA_NPORT  = 5;
    parameter int SA_FLIT_W = 16;
    parameter int SA_HDR_W  = 11;

    typedef enum logic [2:0] {
        PORT_NORTH = 3'd0,
        PORT_SOUTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_WEST  = 3'd3,
        PORT_LOCAL = 3'd4
    } sa_port_e;
endpackage

// File: rtl/sa_lru_arbiter.sv
// Least-recently-granted arbiter for one output.
// Holds an ordered list of requester indices (slot 0 = highest priority).
// Grants the first listed requester that asks, moves it to the tail on the
// rising edge, and freezes the list when disabled or idle.
// Assumes synchronous active-low reset.
module sa_lru_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ord_q [N];
    logic [IW-1:0] ord_d [N];
    logic          hit;
    int            pos;

    // Find the highest-priority slot whose requester is asking.
    always_comb begin
        hit = 1'b0;
        pos = 0;
        for (int p = 0; p < N; p++) begin
            if (!hit && req[ord_q[p]]) begin
                hit = 1'b1;
                pos = p;
            end
        end
    end

    // Drive the one-hot grant when enabled and out of reset.
    always_comb begin
        gnt = '0;
        if (rst_n && en && hit) begin
            gnt[ord_q[pos]] = 1'b1;
        end
    end

    // Build the next order: winner goes to the tail, the rest close up.
    always_comb begin
        for (int p = 0; p < N - 1; p++) begin
            if (p < pos) begin
                ord_d[p] = ord_q[p];
            end else begin
                ord_d[p] = ord_q[p + 1];
            end
        end
        ord_d[N-1] = ord_q[pos];
    end

    // Load reset order or commit the rotation on a granting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                ord_q[p] <= IW'(p);
            end
        end else if (|gnt) begin
            for (int p = 0; p < N; p++) begin
                ord_q[p] <= ord_d[p];
            end
        end
    end
endmodule

// File: rtl/sa_xbar_mux.sv
// One crossbar output column: AND-OR multiplexer selected by a one-hot
// grant vector. Assumes at most one select bit is high; with none high the
// output is zero and valid is low.
module sa_xbar_mux #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout,
    output logic           valid
);
    // Merge the selected lane into the output word.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i*W +: W] & {W{sel[i]}});
        end
    end

    // Valid whenever any lane is selected.
    always_comb begin
        valid = |sel;
    end
endmodule

// File: rtl/sa_flit_pad.sv
// Input conditioning: when the flit is a header, clear every bit above the
// header width so the header travels the full-width crossbar zero-padded.
// Assumes HW < W.
module sa_flit_pad #(
    parameter int W  = 16,
    parameter int HW = 11
) (
    input  logic         is_hdr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam logic [W-1:0] HDR_MASK = {{(W-HW){1'b0}}, {HW{1'b1}}};

    // Apply the header mask only to header flits.
    always_comb begin
        dout = is_hdr ? (din & HDR_MASK) : din;
    end
endmodule

// File: rtl/sa_switch_alloc.sv
// Switch allocator plus crossbar for a five-port mesh router.
// Regroups the request matrix per output, runs one LRU arbiter per output
// gated by downstream flow control, feeds the one-hot grants straight into
// the crossbar column multiplexers, and folds grants back per input.
// Assumes each input requests at most one output (dimension-order routing).
module sa_switch_alloc
    import sa_pkg::*;
#(
    parameter int NPORT  = SA_NPORT,
    parameter int FLIT_W = SA_FLIT_W,
    parameter int HDR_W  = SA_HDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT*NPORT-1:0]  req,
    input  logic [NPORT-1:0]        flow_on,
    input  logic [NPORT*FLIT_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_hdr,
    output logic [NPORT*FLIT_W-1:0] out_data,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*NPORT-1:0]  out_gnt,
    output logic [NPORT-1:0]        in_grant
);
    localparam int NREQ = NPORT * NPORT;

    logic [NPORT-1:0]        req_col [NPORT];
    logic [NPORT-1:0]        gnt_col [NPORT];
    logic [NPORT*FLIT_W-1:0] pad_data;

    // Input side: pad header flits per input.
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        sa_flit_pad #(
            .W  (FLIT_W),
            .HW (HDR_W)
        ) u_pad (
            .is_hdr (in_hdr[gi]),
            .din    (in_data[gi*FLIT_W +: FLIT_W]),
            .dout   (pad_data[gi*FLIT_W +: FLIT_W])
        );
    end

    // Output side: regroup requests, arbitrate, and select data.
    for (genvar go = 0; go < NPORT; go++) begin : g_out
        // Collect the requests aimed at this output from every input.
        always_comb begin
            for (int i = 0; i < NPORT; i++) begin
                req_col[go][i] = req[i*NPORT + go];
            end
        end

        sa_lru_arbiter #(
            .N (NPORT)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (flow_on[go]),
            .req   (req_col[go]),
            .gnt   (gnt_col[go])
        );

        sa_xbar_mux #(
            .N (NPORT),
            .W (FLIT_W)
        ) u_mux (
            .sel   (gnt_col[go]),
            .din   (pad_data),
            .dout  (out_data[go*FLIT_W +: FLIT_W]),
            .valid (out_valid[go])
        );

        // Publish this output's grant row.
        always_comb begin
            out_gnt[go*NPORT +: NPORT] = gnt_col[go];
        end
    end

    // Fold grants per input so each input learns it was served.
    always_comb begin
        in_grant = '0;
        for (int o = 0; o < NPORT; o++) begin
            in_grant = in_grant | gnt_col[o];
        end
    end

    // Width sanity: request and grant matrices share one size.
    initial begin
        if ($bits(req) != NREQ || $bits(out_gnt) != NREQ) begin
            $display("sa_switch_alloc: matrix width mismatch");
        end
    end
endmodule

// File: rtl/sa_switch_alloc_chk.sv
// Property checker for the switch allocator, attached by bind.
// Observes only the top-level ports.
module sa_switch_alloc_chk #(
    parameter int NPORT  = 5,
    parameter int FLIT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT*NPORT-1:0]  req,
    input logic [NPORT-1:0]        flow_on,
    input logic [NPORT*FLIT_W-1:0] out_data,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT*NPORT-1:0]  out_gnt
);
    logic [NPORT-1:0] rq [NPORT];
    logic [NPORT-1:0] gr [NPORT];

    // Regroup request and grant bits per output for the properties.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                rq[o][i] = req[i*NPORT + o];
                gr[o][i] = out_gnt[o*NPORT + i];
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gr[o]));

        p_grant_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gr[o] & ~rq[o]) == '0);

        p_flow_off_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !flow_on[o] |-> (gr[o] == '0 && !out_valid[o]));

        p_work_conserving_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flow_on[o] && rq[o] != '0) |-> gr[o] != '0);

        p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[o] |-> out_data[o*FLIT_W +: FLIT_W] == '0);

        for (genvar i = 0; i < NPORT; i++) begin : g_i
            // R5: a winner yields to any other requester on the next grant.
            p_winner_yields_r5: assert property (@(posedge clk) disable iff (!rst_n)
                gr[o][i] |=> ((flow_on[o] && (rq[o] & ~(NPORT'(1) << i)) != '0)
                              -> !gr[o][i]));
        end
    end
endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(
    .NPORT  (NPORT),
    .FLIT_W (FLIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .flow_on   (flow_on),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_gnt   (out_gnt)
);

// File: tb/sa_switch_alloc_test.sv
// Self-checking bench: vector table walk, then directed reset checks.
module sa_switch_alloc_test;
    localparam int PERIOD = 10;
    localparam int NP = 5;
    localparam int FW = 16;
    localparam logic [2:0] NO = 3'd7;

    typedef struct packed {
        logic [14:0] dest;   // {in4..in0}, output index or NO
        logic [4:0]  flow;
        logic [4:0]  hdr;
        logic [14:0] win;    // {out4..out0}, winning input or NO
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{ {3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, {NO,NO,NO,NO,3'd0} },
        '{ {3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, {NO,NO,NO,NO,3'd1} },
        '{ {NO,NO,NO,3'd0,3'd0},       5'h1F, 5'h00, {NO,NO,NO,NO,3'd0} },
        '{ {3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1E, 5'h00, {NO,NO,NO,NO,NO}   },
        '{ {3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, {NO,NO,NO,NO,3'd2} },
        '{ {3'd0,3'd4,3'd3,3'd2,3'd1}, 5'h1F, 5'h12, {3'd3,3'd2,3'd1,3'd0,3'd4} },
        '{ {3'd4,3'd1,3'd1,NO,3'd4},   5'h0F, 5'h00, {NO,NO,NO,3'd2,NO}   },
        '{ {3'd4,3'd1,3'd1,NO,3'd4},   5'h1F, 5'h00, {3'd0,NO,NO,3'd3,NO} },
        '{ {NO,NO,NO,NO,NO},           5'h1F, 5'h00, {NO,NO,NO,NO,NO}     },
        '{ {3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, {NO,NO,NO,NO,3'd3} },
        '{ {3'd0,NO,NO,3'd0,3'd3},     5'h1F, 5'h01, {NO,3'd0,NO,NO,3'd1} }
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP*NP-1:0]     req = '0;
    logic [NP-1:0]        flow_on = '1;
    logic [NP*FW-1:0]     in_data = '0;
    logic [NP-1:0]        in_hdr = '0;
    logic [NP*FW-1:0]     out_data;
    logic [NP-1:0]        out_valid;
    logic [NP*NP-1:0]     out_gnt;
    logic [NP-1:0]        in_grant;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    sa_switch_alloc uut (
        .clk (clk), .rst_n (rst_n), .req (req), .flow_on (flow_on),
        .in_data (in_data), .in_hdr (in_hdr), .out_data (out_data),
        .out_valid (out_valid), .out_gnt (out_gnt), .in_grant (in_grant)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [FW-1:0] dval(int i, int s);
        return 16'hA5C3 ^ FW'(i * 16'h1111) ^ FW'(s * 16'h0203);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one pattern: each input aims at dest or nothing.
    task automatic drive(input logic [14:0] dest, input logic [4:0] fl,
                         input logic [4:0] hd, input int s);
        req = '0;
        for (int i = 0; i < NP; i++) begin
            if (dest[3*i +: 3] != NO) req[i*NP + int'(dest[3*i +: 3])] = 1'b1;
            in_data[i*FW +: FW] = dval(i, s);
        end
        flow_on = fl;
        in_hdr = hd;
    endtask

    // Compare all outputs with the expected winners of one pattern.
    task automatic expect_win(input logic [14:0] win, input logic [4:0] hd,
                              input int s);
        logic [NP-1:0] eg;
        eg = '0;
        for (int o = 0; o < NP; o++) begin
            logic [2:0] w;
            logic [NP-1:0] erow;
            logic [FW-1:0] ed;
            w = win[3*o +: 3];
            erow = (w == NO) ? '0 : (NP'(1) << w);
            ed = '0;
            if (w != NO) begin
                ed = dval(int'(w), s);
                if (hd[w]) ed = ed & 16'h07FF;   // R8 header padding
                eg[w] = 1'b1;
            end
            chk(out_gnt[o*NP +: NP] == erow, "R1 R2 R3 R4 R5 grant row",
                32'(out_gnt[o*NP +: NP]), 32'(erow));
            chk(out_valid[o] == (w != NO), "R6 R7 valid",
                32'(out_valid[o]), 32'(w != NO));
            chk(out_data[o*FW +: FW] == ed, "R6 R7 R8 data",
                32'(out_data[o*FW +: FW]), 32'(ed));
        end
        chk(in_grant == eg, "R9 input grant", 32'(in_grant), 32'(eg));
    endtask

    initial begin
        // R10: requests during reset produce no grants.
        drive({3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, 0);
        @(negedge clk); #2;
        chk(out_gnt == '0 && out_valid == '0, "R10 reset grants",
            32'(out_gnt), 32'h0);
        @(negedge clk); #2;
        chk(in_grant == '0, "R10 reset input grant", 32'(in_grant), 32'h0);

        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NV; s++) begin
            if (s > 0) @(negedge clk);
            drive(VEC[s].dest, VEC[s].flow, VEC[s].hdr, s);
            #2;
            expect_win(VEC[s].win, VEC[s].hdr, s);
        end

        // R10: mid-run reset restores order 0 highest on output 0.
        @(negedge clk);
        rst_n = 1'b0;
        drive({3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, 20);
        #2;
        chk(out_gnt == '0 && out_valid == '0, "R10 mid reset grants",
            32'(out_gnt), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        expect_win({NO,NO,NO,NO,3'd0}, 5'h00, 20);   // R10 order restored
        @(negedge clk);
        drive({3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, 21);
        #2;
        expect_win({NO,NO,NO,NO,3'd1}, 5'h00, 21);   // R5 rotation

        // R3: all flow off with requests; then the order is unchanged.
        @(negedge clk);
        drive({3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h00, 5'h00, 22);
        #2;
        expect_win({NO,NO,NO,NO,NO}, 5'h00, 22);
        @(negedge clk);
        drive({3'd0,3'd0,3'd0,3'd0,3'd0}, 5'h1F, 5'h00, 23);
        #2;
        expect_win({NO,NO,NO,NO,3'd2}, 5'h00, 23);   // R3 state frozen

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule